// File: doc/BRIEF.md
# Shared-Cascade Multichannel Decimation Filter

This block takes a parallel bus of simultaneously sampled 16-bit channels, one frame per sample slot, and runs every channel through a single time-shared cascade of halve-the-rate low-pass stages. Each stage keeps its own history for each channel in a small state store addressed by (channel, stage). The stage outputs are called taps: tap 0 is the raw input, and tap k has been halved k times.

A set of output slots is configured through plain inputs. Each slot names a channel, a path (fast or slow) and a rate code. The fast path maps the rate code straight onto a tap, so it runs from the full frame rate down by powers of two. The slow path starts three halvings down and goes deeper from there. Whenever the cascade produces a sample on a slot's (channel, tap), that slot gets a one-cycle valid strobe and the data. A timing-cycle pulse realigns the decimation phase of every stage, so all channels and rates stay sample-aligned to a common epoch.

A controller sequences the work with four states:
- `S_IDLE`: waits for a frame. On a frame it latches the bus and, if a sync is pending, clears all phases. It then moves to `S_TAP0`.
- `S_TAP0`: publishes the raw sample of the current channel. It then moves to `S_STAGE`.
- `S_STAGE`: runs one stage per cycle for the current channel and moves deeper only while a stage emits. When the walk stops or reaches the last stage, it moves to `S_NEXT`.
- `S_NEXT`: moves to `S_TAP0` for the next channel, or back to `S_IDLE` after the last channel.

Top module: `dec_chain`

## Requirements
- R1: Reset behaviour: after reset, every `out_valid` bit is 0, all `out_data` is 0, all filter histories are 0 and all decimation phases are 0.
- R2: Tap 0 of a channel equals the latched raw sample of that channel, and it is produced once per accepted frame.
- R3: Each stage computes a filter with coefficients (-1, 0, 9, 16, 9, 0, -1)/32 over its newest seven inputs, newest first. The result is rounded as (sum+16) shifted arithmetically right by 5, then saturated to the range -32768..32767.
- R4: A stage whose phase is 0 absorbs its input without output and sets its phase to 1. A stage whose phase is 1 emits a result to the next stage and to the outputs, and sets its phase to 0. Both cases shift the input into the stage history.
- R5: A slot on the fast path (`cfg_dc` bit = 0) follows tap = rate code, clamped to a maximum of 6.
- R6: A slot on the slow path (`cfg_dc` bit = 1) follows tap = 3 + rate code, with the rate code clamped to a maximum of 14.
- R7: A `sync_in` pulse clears every stage phase of every channel when the next frame is accepted, including a frame in the same cycle. With sync applied at frame 1, tap k first emits on frame 2^k.
- R8: A slot's `out_valid` pulses for one cycle, one cycle after its (channel, tap) is produced. `out_data` holds its value between pulses.
- R9: All processing for a frame ends within NCH*(NSTG+2)+1 cycles of its acceptance, so every output of a frame appears before the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_in | input | 1 | One-cycle strobe: a new sample frame is on `samp_bus` |
| sync_in | input | 1 | Timing-cycle pulse that realigns the decimation phases |
| samp_bus | input | NCH*W | Channel c sample in bits [c*W +: W], two's complement |
| cfg_chan | input | NOUT*CHW | Channel select per slot |
| cfg_dc | input | NOUT | Path select per slot: 0 = fast, 1 = slow |
| cfg_rate | input | NOUT*RW | Rate code per slot |
| out_valid | output | NOUT | Per-slot sample strobe |
| out_data | output | NOUT*W | Per-slot sample, slot s in bits [s*W +: W] |

## Verification
A sync pulse and a frame strobe can arrive in the same cycle. The phase clear must then act before that frame enters any stage, and each stage must treat that frame as its first absorbed input. The bench provokes this in two ways: by raising `sync_in` together with `frame_in` in the middle of a running stream, and separately by raising sync between frames. In both cases a reference cascade, built from R3 and R4, decides frame by frame whether each slot should pulse and with what value. A wrong ordering shows up as an emission one frame early or late on every decimated tap.

// File: rtl/dec_pkg.sv
package dec_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_TAP0,
        S_STAGE,
        S_NEXT
    } dec_state_t;

    localparam int HB_TAPS = 7;
endpackage

// File: rtl/dec_halfband.sv
module dec_halfband #(
    parameter int W = 16
) (
    input  logic [dec_pkg::HB_TAPS*W-1:0] win,
    output logic [W-1:0]                  y
);
    localparam int SUMW = W + 6;
    localparam logic signed [SUMW-1:0] HI = SUMW'((1 << (W - 1)) - 1);
    localparam logic signed [SUMW-1:0] LO = -HI - SUMW'(1);

    logic signed [SUMW-1:0] ext [dec_pkg::HB_TAPS];
    logic signed [SUMW-1:0] sum;
    logic signed [SUMW-1:0] q;

    for (genvar k = 0; k < dec_pkg::HB_TAPS; k++) begin : g_ext
        assign ext[k] = SUMW'($signed(win[k*W +: W]));
    end

    always_comb begin
        sum = -ext[0] + (ext[2] <<< 3) + ext[2] + (ext[3] <<< 4)
              + (ext[4] <<< 3) + ext[4] - ext[6] + SUMW'(16);
        q = sum >>> 5;
        if (q > HI)      y = HI[W-1:0];
        else if (q < LO) y = LO[W-1:0];
        else             y = q[W-1:0];
    end

    // R3: a flat history must pass through with unity gain
    always_comb begin
        if (win[0*W +: W] == win[2*W +: W] && win[0*W +: W] == win[3*W +: W] &&
            win[0*W +: W] == win[4*W +: W] && win[0*W +: W] == win[6*W +: W] &&
            win[0*W +: W] == win[1*W +: W] && win[0*W +: W] == win[5*W +: W]) begin
            a_r3_unity_gain: assert (y == win[0*W +: W])
                else $error("flat input not reproduced");
        end
    end
endmodule

// File: rtl/dec_tap_select.sv
module dec_tap_select #(
    parameter int W       = 16,
    parameter int NOUT    = 4,
    parameter int CHW     = 2,
    parameter int TW      = 5,
    parameter int RW      = 4,
    parameter int AC_MAX  = 6,
    parameter int DC_BASE = 3,
    parameter int DC_MAX  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              emit,
    input  logic [CHW-1:0]    emit_ch,
    input  logic [TW-1:0]     emit_tap,
    input  logic [W-1:0]      emit_data,
    input  logic [NOUT*CHW-1:0] cfg_chan,
    input  logic [NOUT-1:0]   cfg_dc,
    input  logic [NOUT*RW-1:0] cfg_rate,
    output logic [NOUT-1:0]   out_valid,
    output logic [NOUT*W-1:0] out_data
);
    for (genvar s = 0; s < NOUT; s++) begin : g_slot
        int rate_i;
        int tap_i;
        logic hit;

        always_comb begin
            rate_i = int'(cfg_rate[s*RW +: RW]);
            if (cfg_dc[s]) tap_i = DC_BASE + ((rate_i > DC_MAX) ? DC_MAX : rate_i);
            else           tap_i = (rate_i > AC_MAX) ? AC_MAX : rate_i;
            hit = emit && (emit_ch == cfg_chan[s*CHW +: CHW]) && (emit_tap == TW'(tap_i));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid[s]        <= 1'b0;
                out_data[s*W +: W]  <= '0;
            end else begin
                out_valid[s] <= hit;
                if (hit) out_data[s*W +: W] <= emit_data;
            end
        end

        a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
            !out_valid[s] |-> $stable(out_data[s*W +: W]))
            else $error("slot data moved without a strobe");
    end
endmodule

// File: rtl/dec_chain.sv
module dec_chain #(
    parameter int W       = 16,
    parameter int NCH     = 4,
    parameter int NSTG    = 17,
    parameter int NOUT    = 4,
    parameter int RW      = 4,
    parameter int AC_MAX  = 6,
    parameter int DC_BASE = 3,
    parameter int DC_MAX  = 14,
    parameter int CHW     = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_in,
    input  logic                sync_in,
    input  logic [NCH*W-1:0]    samp_bus,
    input  logic [NOUT*CHW-1:0] cfg_chan,
    input  logic [NOUT-1:0]     cfg_dc,
    input  logic [NOUT*RW-1:0]  cfg_rate,
    output logic [NOUT-1:0]     out_valid,
    output logic [NOUT*W-1:0]   out_data
);
    import dec_pkg::*;

    localparam int TW    = $clog2(NSTG + 1);
    localparam int NSLOT = NCH * NSTG;
    localparam int IW    = $clog2(NSLOT);
    localparam int HW    = (HB_TAPS - 1) * W;
    localparam int LIMIT = NCH * (NSTG + 2) + 1;

    dec_state_t state_q, state_d;
    logic [CHW-1:0]   ch_q;
    logic [TW-1:0]    stg_q;
    logic [W-1:0]     cur_q;
    logic [NCH*W-1:0] samp_q;
    logic [HW-1:0]    dly_mem [NSLOT];
    logic [NSLOT-1:0] phase_q;
    logic             sync_pend;
    logic [IW-1:0]    idx;
    logic [W-1:0]     hb_y;
    logic             emit;
    logic [TW-1:0]    emit_tap;
    logic [W-1:0]     emit_data;

    assign idx = IW'(int'(ch_q) * NSTG + int'(stg_q));

    dec_halfband #(.W(W)) u_hb (
        .win ({dly_mem[idx], cur_q}),
        .y   (hb_y)
    );

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (frame_in) state_d = S_TAP0;
            S_TAP0:  state_d = S_STAGE;
            S_STAGE: if (!phase_q[idx] || stg_q == TW'(NSTG - 1)) state_d = S_NEXT;
            S_NEXT:  state_d = (ch_q == CHW'(NCH - 1)) ? S_IDLE : S_TAP0;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // datapath and per-channel state store
    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q      <= '0;
            stg_q     <= '0;
            cur_q     <= '0;
            samp_q    <= '0;
            phase_q   <= '0;
            sync_pend <= 1'b0;
            for (int i = 0; i < NSLOT; i++) dly_mem[i] <= '0;
        end else begin
            sync_pend <= sync_pend | sync_in;
            unique case (state_q)
                S_IDLE: if (frame_in) begin
                    samp_q <= samp_bus;
                    ch_q   <= '0;
                    if (sync_pend || sync_in) begin
                        phase_q   <= '0;
                        sync_pend <= 1'b0;
                    end
                end
                S_TAP0: begin
                    cur_q <= samp_q[ch_q*W +: W];
                    stg_q <= '0;
                end
                S_STAGE: begin
                    dly_mem[idx] <= {dly_mem[idx][HW-W-1:0], cur_q};
                    phase_q[idx] <= ~phase_q[idx];
                    if (phase_q[idx]) begin
                        cur_q <= hb_y;
                        stg_q <= stg_q + 1'b1;
                    end
                end
                S_NEXT: ch_q <= ch_q + 1'b1;
                default: ;
            endcase
        end
    end

    // emission outputs
    always_comb begin
        emit      = 1'b0;
        emit_tap  = '0;
        emit_data = '0;
        unique case (state_q)
            S_TAP0: begin
                emit      = 1'b1;
                emit_data = samp_q[ch_q*W +: W];
            end
            S_STAGE: begin
                emit      = phase_q[idx];
                emit_tap  = stg_q + 1'b1;
                emit_data = hb_y;
            end
            default: ;
        endcase
    end

    dec_tap_select #(
        .W(W), .NOUT(NOUT), .CHW(CHW), .TW(TW), .RW(RW),
        .AC_MAX(AC_MAX), .DC_BASE(DC_BASE), .DC_MAX(DC_MAX)
    ) u_sel (
        .clk(clk), .rst(rst), .emit(emit), .emit_ch(ch_q), .emit_tap(emit_tap),
        .emit_data(emit_data), .cfg_chan(cfg_chan), .cfg_dc(cfg_dc), .cfg_rate(cfg_rate),
        .out_valid(out_valid), .out_data(out_data)
    );

    // checker state
    logic [IW-1:0] chk_idx;
    logic          chk_ph;
    logic [15:0]   busy_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_idx  <= '0;
            chk_ph   <= 1'b0;
            busy_cnt <= '0;
        end else begin
            chk_idx  <= idx;
            chk_ph   <= phase_q[idx];
            busy_cnt <= (state_q == S_IDLE) ? 16'd0 : busy_cnt + 16'd1;
        end
    end

    a_r4_phase_flips: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_STAGE) |=> (phase_q[chk_idx] != chk_ph))
        else $error("stage phase did not alternate");

    a_r7_sync_clears: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && frame_in && (sync_in || sync_pend)) |=> (phase_q == '0))
        else $error("phases not cleared by sync");

    a_r9_budget: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= 16'(LIMIT))
        else $error("frame processing over budget");

    a_r9_no_overrun: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE) |-> !frame_in)
        else $error("frame arrived while busy");
endmodule

// File: tb/dec_chain_test.sv
module dec_chain_test;
    localparam int W = 16, NCH = 4, NSTG = 17, NOUT = 4, RW = 4, CHW = 2;
    localparam int GAP = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_in = 1'b0, sync_in = 1'b0;
    logic [NCH*W-1:0]    samp_bus = '0;
    logic [NOUT*CHW-1:0] cfg_chan = '0;
    logic [NOUT-1:0]     cfg_dc = '0;
    logic [NOUT*RW-1:0]  cfg_rate = '0;
    logic [NOUT-1:0]     out_valid;
    logic [NOUT*W-1:0]   out_data;

    dec_chain uut (
        .clk(clk), .rst(rst), .frame_in(frame_in), .sync_in(sync_in), .samp_bus(samp_bus),
        .cfg_chan(cfg_chan), .cfg_dc(cfg_dc), .cfg_rate(cfg_rate),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference cascade built from R3/R4/R7
    int  m_dly [NCH][NSTG][6];
    bit  m_ph  [NCH][NSTG];
    bit  m_emit[NCH][NSTG+1];
    int  m_val [NCH][NSTG+1];
    bit  m_pend = 0;

    int  got_cnt [NOUT];
    int  got_val [NOUT];
    bit  saw_max [NOUT];

    always @(negedge clk) begin
        for (int s = 0; s < NOUT; s++) begin
            if (out_valid[s]) begin
                got_cnt[s]++;
                got_val[s] = int'($signed(out_data[s*W +: W]));
                if (got_val[s] == 32767) saw_max[s] = 1;
            end
        end
    end

    function automatic int hb(int x0, int x2, int x3, int x4, int x6);
        int q;
        q = (-x0 + 9*x2 + 16*x3 + 9*x4 - x6 + 16) >>> 5;
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return q;
    endfunction

    function automatic int tap_of(bit dc, int rate);
        if (dc) return 3 + ((rate > 14) ? 14 : rate);
        return (rate > 6) ? 6 : rate;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < NSTG; k++) begin
                m_ph[c][k] = 0;
                for (int j = 0; j < 6; j++) m_dly[c][k][j] = 0;
            end
        m_pend = 0;
    endtask

    task automatic model_frame(int smp[NCH]);
        int cur, y;
        bit go;
        if (m_pend)
            for (int c = 0; c < NCH; c++)
                for (int k = 0; k < NSTG; k++) m_ph[c][k] = 0;
        m_pend = 0;
        for (int c = 0; c < NCH; c++) begin
            for (int t = 0; t <= NSTG; t++) m_emit[c][t] = 0;
            cur = smp[c];
            m_emit[c][0] = 1; m_val[c][0] = cur;
            go = 1;
            for (int k = 0; k < NSTG && go; k++) begin
                y = hb(cur, m_dly[c][k][1], m_dly[c][k][2], m_dly[c][k][3], m_dly[c][k][5]);
                for (int j = 5; j > 0; j--) m_dly[c][k][j] = m_dly[c][k][j-1];
                m_dly[c][k][0] = cur;
                if (m_ph[c][k]) begin
                    m_ph[c][k] = 0;
                    cur = y;
                    m_emit[c][k+1] = 1; m_val[c][k+1] = y;
                end else begin
                    m_ph[c][k] = 1;
                    go = 0;
                end
            end
        end
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_slot(int s, int ch, bit dc, int rate);
        cfg_chan[s*CHW +: CHW] = CHW'(ch);
        cfg_dc[s]              = dc;
        cfg_rate[s*RW +: RW]   = RW'(rate);
    endtask

    // drive one frame, then compare every slot against the model (R8/R9 timing)
    task automatic run_frame(int smp[NCH], bit sync, string req);
        int c, t;
        @(negedge clk);
        for (int s = 0; s < NOUT; s++) got_cnt[s] = 0;
        for (int i = 0; i < NCH; i++) samp_bus[i*W +: W] = W'(smp[i]);
        frame_in = 1'b1;
        sync_in  = sync;
        if (sync) m_pend = 1;
        model_frame(smp);
        @(negedge clk);
        frame_in = 1'b0;
        sync_in  = 1'b0;
        repeat (GAP) @(negedge clk);
        for (int s = 0; s < NOUT; s++) begin
            c = int'(cfg_chan[s*CHW +: CHW]);
            t = tap_of(cfg_dc[s], int'(cfg_rate[s*RW +: RW]));
            check(got_cnt[s] == int'(m_emit[c][t]), req, "strobe count (R8 R9)",
                  got_cnt[s], int'(m_emit[c][t]));
            if (m_emit[c][t])
                check(got_val[s] == m_val[c][t], req, "sample value", got_val[s], m_val[c][t]);
        end
    endtask

    function automatic int mix(int f, int c);
        int v;
        v = (f * 1237 + c * 4099 + ((f * f) % 311) * 37) % 65536;
        if (v >= 32768) v -= 65536;
        return v;
    endfunction

    task automatic t_reset();
        check(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(out_data == '0, "R1", "out_data after reset", 0, 0);
    endtask

    task automatic t_stream_and_joint_sync();
        int smp[NCH];
        set_slot(0, 1, 0, 0);   // R2 raw tap
        set_slot(1, 0, 0, 1);   // R3 R4 one halving
        set_slot(2, 2, 1, 0);   // R6 slow path base (tap 3)
        set_slot(3, 3, 0, 2);   // R4 two halvings
        for (int f = 0; f < 64; f++) begin
            for (int c = 0; c < NCH; c++) smp[c] = mix(f, c);
            run_frame(smp, 0, "R2/R3/R4/R6");
        end
        // R7: sync together with a frame mid-stream
        for (int f = 0; f < 40; f++) begin
            for (int c = 0; c < NCH; c++) smp[c] = mix(f + 500, c);
            run_frame(smp, f == 0, "R7");
        end
    endtask

    task automatic t_saturation();
        int smp[NCH];
        int pat[6] = '{32767, -32768, 32767, 32767, 32767, 32767};
        set_slot(1, 0, 0, 1);
        saw_max[1] = 0;
        for (int f = 0; f < 24; f++) begin
            for (int c = 0; c < NCH; c++) smp[c] = pat[f % 6];
            run_frame(smp, f == 0, "R3");
        end
        check(saw_max[1], "R3", "clipped to positive limit", int'(saw_max[1]), 1);
    endtask

    task automatic t_clamp();
        int smp[NCH];
        set_slot(0, 0, 0, 9);    // R5 clamps to tap 6
        set_slot(1, 1, 1, 2);    // R6 tap 5
        set_slot(2, 2, 1, 15);   // R6 clamps to tap 17
        set_slot(3, 3, 0, 3);    // R5 tap 3
        for (int f = 0; f < 130; f++) begin
            for (int c = 0; c < NCH; c++) smp[c] = mix(f + 900, c) / 2;
            run_frame(smp, f == 0, "R5/R6");
        end
    endtask

    task automatic t_sync_alone();
        int smp[NCH];
        set_slot(0, 2, 0, 2);
        set_slot(3, 1, 0, 1);
        // sync between frames, no frame that cycle
        @(negedge clk); sync_in = 1'b1; m_pend = 1;
        @(negedge clk); sync_in = 1'b0;
        for (int f = 0; f < 20; f++) begin
            for (int c = 0; c < NCH; c++) smp[c] = mix(f + 1300, c);
            run_frame(smp, 0, "R7");
        end
    endtask

    initial begin
        for (int s = 0; s < NOUT; s++) begin got_cnt[s] = 0; got_val[s] = 0; saw_max[s] = 0; end
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stream_and_joint_sync();
        t_saturation();
        t_clamp();
        t_sync_alone();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule